// File: doc/BRIEF.md
# Cascaded Converter Serial Port Node

This block is the digital side of one converter channel's serial port. Identical channels are wired in a ring with a host serial port. Each node receives 16-bit words framed by an input frame sync and passes words on to the next node with its own output frame sync. When a sample event occurs, every node loads its fresh ADC word into its shift register and raises its output frame sync. The ADC words then move one hop per frame toward the host.

The node starts in program mode. In this mode a received control word carries a device address. A node that sees address zero takes the word for itself. A node that sees any other address decrements the address by one and forwards the word. The host therefore sends the word for the farthest node first. When every word in a burst has moved the full distance, each node holds its own word, and all nodes update in the same cycle. Setting the mode bit switches the node to data mode. In data mode the node ignores addresses and counts received frames. The frame that brings the count up to the programmed cascade length is latched as the new DAC word. All earlier frames are passed on.

The serial link has no back-pressure. Frames cannot be stalled. A frame must start in the same cycle as the node's own output frame sync, or when the node is idle. This alignment occurs naturally when the frame syncs are looped back through the chain. The parallel ADC input is sampled only on the clock where `sample_evt` is high. The DAC output is valid for the one cycle in which `dac_stb` is high, and it then holds its value.

Top module: `cascade_port_node`

## Requirements
- R1: After a synchronous reset, `ctrl_a` is 0x01 (cascade length one, program mode), `ctrl_b` is 0x00, `dac_word` is 0x0000, and `dac_stb` and `sout_fs` are low.
- R2: `sample_evt` high at a clock edge raises `sout_fs` for the following cycle. The `adc_word` captured at that edge then appears on `sout_data`, MSB first, one bit per cycle for the next 16 cycles.
- R3: A frame sync marks the cycle before its first bit. `sin_fs` is sampled at one edge, and the 16 data bits are sampled MSB first at the next 16 edges. Any forwarding `sout_fs` is raised in the cycle right after the edge that took the last bit. A frame that only the node's own `sout_fs` started is never processed as a word.
- R4: In program mode, a control word has bit 15 = 1. If its device address (bits 13:11) is 0 and its write flag (bit 14) is 1, data bits 7:0 are written to the register selected by bits 10:8: 0 selects `ctrl_a` and 1 selects `ctrl_b`. The word is not forwarded.
- R5: In program mode, a control word with a nonzero device address is forwarded with the address field decremented by one and every other bit unchanged.
- R6: In program mode, a word with bit 15 = 0 is forwarded unchanged.
- R7: In program mode, a control word with device address 0 and write flag 0 is forwarded with bits 7:0 replaced. They become `ctrl_a` for register 0, `ctrl_b` for register 1, and 0x00 for any other register.
- R8: A write that selects a register address other than 0 or 1 changes neither register and is not forwarded.
- R9: Bits 2:0 of `ctrl_a` hold the cascade length, where 0 means eight. Bit 3 is the mode bit, and 1 selects data mode. All 8 bits of `ctrl_b` are stored and presented as written: bits 2:0 are the master-clock divider and bits 5:4 are the serial-clock select.
- R10: In data mode every processed word counts as one frame. A word that leaves the count below the cascade length is forwarded unchanged. The word that reaches the length is copied to `dac_word`, `dac_stb` is high for exactly one cycle, the word is not forwarded, and the count restarts from zero.
- R11: In data mode, address fields are not interpreted. Control words are counted and forwarded like any other word, and neither control register can change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_evt | input | 1 | Sample event pulse; loads `adc_word` and raises `sout_fs` |
| adc_word | input | 16 | Parallel ADC result captured on a sample event |
| sin_fs | input | 1 | Input frame sync, high in the cycle before the first bit |
| sin_data | input | 1 | Serial input data, MSB first |
| sout_fs | output | 1 | Output frame sync toward the next node |
| sout_data | output | 1 | Serial output data, MSB of the shift register |
| dac_word | output | 16 | Last latched DAC word |
| dac_stb | output | 1 | One-cycle pulse when `dac_word` takes a new value |
| ctrl_a | output | 8 | Control register A (cascade length, mode bit) |
| ctrl_b | output | 8 | Control register B (clock divider and serial-clock select) |

## Verification
The hardest case to reach is the wrap of the data-mode frame counter when the cascade-length field is zero. It takes a register write in program mode and then eight complete frames in a row, each started in the same cycle as the forwarding frame sync of the frame before. The bench starts every new frame in exactly the cycle where the node raises `sout_fs`, so the frames are chained back to back. It checks that the first seven frames are passed on and that only the eighth produces a DAC strobe. The same chaining is used to read back forwarded words, such as decremented addresses and register reads, bit by bit from `sout_data` while the next word is shifted in.

// File: rtl/cpn_pkg.sv
package cpn_pkg;

  // What the node does with a completed incoming word
  typedef enum logic [1:0] {
    RT_FWD   = 2'd0,   // pass (possibly modified) word downstream
    RT_WRITE = 2'd1,   // absorb and write a control register
    RT_LATCH = 2'd2    // absorb and latch into the DAC register
  } route_e;

endpackage

// File: rtl/cpn_shifter.sv
module cpn_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              sin_fs,
  input  logic              sin_data,
  input  logic              fwd,
  input  logic [WORD_W-1:0] fwd_word,
  output logic              sout_fs,
  output logic              sout_data,
  output logic [WORD_W-1:0] rx_word,
  output logic              done
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  bcnt;
  logic              busy;
  logic              got_in;

  // word as it stands after the shift taken at this edge
  assign rx_word   = {sreg[WORD_W-2:0], sin_data};
  assign done      = busy && got_in && (bcnt == LAST);
  assign sout_data = sreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      bcnt    <= '0;
      busy    <= 1'b0;
      got_in  <= 1'b0;
      sout_fs <= 1'b0;
    end else begin
      sout_fs <= load | (done & fwd);
      if (load) begin
        sreg   <= load_word;
        busy   <= 1'b0;
        got_in <= 1'b0;
        bcnt   <= '0;
      end else if (busy) begin
        sreg <= (done && fwd) ? fwd_word : rx_word;
        if (bcnt == LAST) begin
          busy <= 1'b0;
          bcnt <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end else if (sin_fs || sout_fs) begin
        busy   <= 1'b1;
        got_in <= sin_fs;
        bcnt   <= '0;
      end
    end
  end

  // R2
  load_fs_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> sout_fs);

  // R2
  load_msb_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (sout_data == $past(load_word[WORD_W-1])));

  // R3
  fs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    sout_fs |-> !busy);

endmodule

// File: rtl/cpn_router.sv
module cpn_router
  import cpn_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEV_AW = 3,
  parameter int REG_AW = 3
) (
  input  logic [WORD_W-1:0]                      rx_word,
  input  logic                                   data_mode,
  input  logic [DEV_AW-1:0]                      dev_count,
  input  logic [DEV_AW-1:0]                      fcnt,
  input  logic [WORD_W-2-DEV_AW-REG_AW-1:0]      reg_a,
  input  logic [WORD_W-2-DEV_AW-REG_AW-1:0]      reg_b,
  output route_e                                 route,
  output logic [WORD_W-1:0]                      tx_word
);

  localparam int DATA_W = WORD_W - 2 - DEV_AW - REG_AW;
  localparam int CTL_B  = WORD_W - 1;
  localparam int RW_B   = WORD_W - 2;
  localparam int REG_LO = DATA_W;
  localparam int DEV_LO = DATA_W + REG_AW;

  logic [DEV_AW-1:0] dev;
  logic [REG_AW-1:0] rsel;
  logic [DATA_W-1:0] rd_val;

  assign dev  = rx_word[DEV_LO +: DEV_AW];
  assign rsel = rx_word[REG_LO +: REG_AW];

  always_comb begin
    if (rsel == REG_AW'(0))      rd_val = reg_a;
    else if (rsel == REG_AW'(1)) rd_val = reg_b;
    else                         rd_val = '0;
  end

  always_comb begin
    tx_word = rx_word;
    route   = RT_FWD;
    if (data_mode) begin
      // count 0 wraps to all-ones, i.e. the maximum cascade length
      if (fcnt == DEV_AW'(dev_count - 1'b1)) route = RT_LATCH;
    end else if (rx_word[CTL_B]) begin
      if (dev != '0)          tx_word[DEV_LO +: DEV_AW] = dev - 1'b1;
      else if (rx_word[RW_B]) route = RT_WRITE;
      else                    tx_word[DATA_W-1:0] = rd_val;
    end
  end

endmodule

// File: rtl/cpn_ctrl_regs.sv
module cpn_ctrl_regs
  import cpn_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEV_AW = 3,
  parameter int REG_AW = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               done,
  input  route_e                             route,
  input  logic [WORD_W-1:0]                  rx_word,
  output logic [WORD_W-2-DEV_AW-REG_AW-1:0]  reg_a,
  output logic [WORD_W-2-DEV_AW-REG_AW-1:0]  reg_b,
  output logic                               data_mode,
  output logic [DEV_AW-1:0]                  dev_count,
  output logic [DEV_AW-1:0]                  fcnt,
  output logic [WORD_W-1:0]                  dac_word,
  output logic                               dac_stb
);

  localparam int DATA_W = WORD_W - 2 - DEV_AW - REG_AW;
  localparam int N_CREG = 2;

  logic [N_CREG-1:0][DATA_W-1:0] creg_q;
  logic [REG_AW-1:0]             rsel;
  logic                          wr_ok;
  logic                          latch_ok;

  assign rsel     = rx_word[DATA_W +: REG_AW];
  assign wr_ok    = done && (route == RT_WRITE);
  assign latch_ok = done && (route == RT_LATCH);

  for (genvar g = 0; g < N_CREG; g++) begin : g_creg
    localparam logic [DATA_W-1:0] RST_V = {{(DATA_W-1){1'b0}}, (g == 0)};
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= RST_V;
      else if (wr_ok && rsel == REG_AW'(g))   q <= rx_word[DATA_W-1:0];
    end
    assign creg_q[g] = q;
  end

  assign reg_a     = creg_q[0];
  assign reg_b     = creg_q[1];
  assign dev_count = reg_a[DEV_AW-1:0];
  assign data_mode = reg_a[DEV_AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt     <= '0;
      dac_word <= '0;
      dac_stb  <= 1'b0;
    end else begin
      dac_stb <= latch_ok;
      if (latch_ok) begin
        dac_word <= rx_word;
        fcnt     <= '0;
      end else if (done && data_mode) begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  // R10
  latch_mode_chk: assert property (@(posedge clk) disable iff (rst)
    dac_stb |-> data_mode);

  // R10
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dac_stb |=> !dac_stb);

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_count != '0) |-> (fcnt < dev_count));

  // R11
  reg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(creg_q) |-> !$past(data_mode));

endmodule

// File: rtl/cascade_port_node.sv
module cascade_port_node
  import cpn_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEV_AW = 3,
  parameter int REG_AW = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               sample_evt,
  input  logic [WORD_W-1:0]                  adc_word,
  input  logic                               sin_fs,
  input  logic                               sin_data,
  output logic                               sout_fs,
  output logic                               sout_data,
  output logic [WORD_W-1:0]                  dac_word,
  output logic                               dac_stb,
  output logic [WORD_W-2-DEV_AW-REG_AW-1:0]  ctrl_a,
  output logic [WORD_W-2-DEV_AW-REG_AW-1:0]  ctrl_b
);

  localparam int DATA_W = WORD_W - 2 - DEV_AW - REG_AW;

  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] tx_word;
  logic              done;
  route_e            route;
  logic              data_mode;
  logic [DEV_AW-1:0] dev_count;
  logic [DEV_AW-1:0] fcnt;
  logic [DATA_W-1:0] reg_a;
  logic [DATA_W-1:0] reg_b;

  cpn_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (sample_evt),
    .load_word (adc_word),
    .sin_fs    (sin_fs),
    .sin_data  (sin_data),
    .fwd       (route == RT_FWD),
    .fwd_word  (tx_word),
    .sout_fs   (sout_fs),
    .sout_data (sout_data),
    .rx_word   (rx_word),
    .done      (done)
  );

  cpn_router #(.WORD_W(WORD_W), .DEV_AW(DEV_AW), .REG_AW(REG_AW)) u_route (
    .rx_word   (rx_word),
    .data_mode (data_mode),
    .dev_count (dev_count),
    .fcnt      (fcnt),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .route     (route),
    .tx_word   (tx_word)
  );

  cpn_ctrl_regs #(.WORD_W(WORD_W), .DEV_AW(DEV_AW), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .route     (route),
    .rx_word   (rx_word),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .data_mode (data_mode),
    .dev_count (dev_count),
    .fcnt      (fcnt),
    .dac_word  (dac_word),
    .dac_stb   (dac_stb)
  );

  assign ctrl_a = reg_a;
  assign ctrl_b = reg_b;

  // R4
  no_fwd_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (done && route == RT_WRITE && !sample_evt) |=> !sout_fs);

endmodule

// File: tb/sim_cascade_port_node.sv
module sim_cascade_port_node;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_evt = 1'b0;
  logic [15:0] adc_word = '0;
  logic        sin_fs = 1'b0;
  logic        sin_data = 1'b0;
  logic        sout_fs;
  logic        sout_data;
  logic [15:0] dac_word;
  logic        dac_stb;
  logic [7:0]  ctrl_a;
  logic [7:0]  ctrl_b;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cascade_port_node u0 (
    .clk(clk), .rst(rst), .sample_evt(sample_evt), .adc_word(adc_word),
    .sin_fs(sin_fs), .sin_data(sin_data), .sout_fs(sout_fs), .sout_data(sout_data),
    .dac_word(dac_word), .dac_stb(dac_stb), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sin_fs = 1'b0; sin_data = 1'b0; sample_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Called at a negedge: the frame sync (own or driven here) is sampled at
  // the next rising edge. Returns at the negedge after the last bit edge.
  task automatic frame_io(input logic send, input logic [15:0] win,
                          output logic [15:0] wout);
    sin_fs = send;
    @(negedge clk);
    sin_fs = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      sin_data = win[i];
      wout[i]  = sout_data;
      @(negedge clk);
    end
    sin_data = 1'b0;
  endtask

  task automatic sample(input logic [15:0] adc);
    sample_evt = 1'b1;
    adc_word   = adc;
    @(negedge clk);
    sample_evt = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 ctrl_a", {8'h0, ctrl_a}, 16'h0001);
    check("R1 ctrl_b", {8'h0, ctrl_b}, 16'h0000);
    check("R1 dac_word", dac_word, 16'h0000);
    check("R1 dac_stb/sout_fs", {14'h0, dac_stb, sout_fs}, 16'h0000);
  endtask

  task automatic test_adc_pass();
    logic [15:0] w;
    sample(16'hA5C3);
    check("R2 fs after sample", {15'h0, sout_fs}, 16'h0001);
    frame_io(1'b1, 16'h1234, w);
    check("R2 adc word shifted out", w, 16'hA5C3);
    check("R3/R6 forward fs", {15'h0, sout_fs}, 16'h0001);
    frame_io(1'b1, 16'hC80A, w);
    check("R6 plain word unchanged", w, 16'h1234);
    check("R5 forward fs", {15'h0, sout_fs}, 16'h0001);
    frame_io(1'b1, 16'h9F00, w);
    check("R5 address 1 decremented", w, 16'hC00A);
    frame_io(1'b0, 16'h0000, w);
    check("R5 address 3 decremented", w, 16'h9700);
    check("R3 own-fs frame not processed", {15'h0, sout_fs}, 16'h0000);
  endtask

  task automatic test_write_read();
    logic [15:0] w;
    frame_io(1'b1, 16'hC137, w);
    check("R4 ctrl_b written", {8'h0, ctrl_b}, 16'h0037);
    check("R4 write not forwarded", {15'h0, sout_fs}, 16'h0000);
    frame_io(1'b1, 16'h8100, w);
    check("R7 read forwarded", {15'h0, sout_fs}, 16'h0001);
    frame_io(1'b1, 16'h8000, w);
    check("R7 read reg B", w, 16'h8137);
    frame_io(1'b1, 16'h86AA, w);
    check("R7 read reg A", w, 16'h8001);
    frame_io(1'b0, 16'h0000, w);
    check("R7 read unknown reg", w, 16'h8600);
  endtask

  task automatic test_bad_reg();
    logic [15:0] w;
    frame_io(1'b1, 16'hC5FF, w);
    check("R8 ctrl_a kept", {8'h0, ctrl_a}, 16'h0001);
    check("R8 ctrl_b kept", {8'h0, ctrl_b}, 16'h0037);
    check("R8 not forwarded", {15'h0, sout_fs}, 16'h0000);
  endtask

  task automatic test_data_mode();
    logic [15:0] w;
    frame_io(1'b1, 16'hC00A, w);
    check("R9 ctrl_a mode+count", {8'h0, ctrl_a}, 16'h000A);
    frame_io(1'b1, 16'h8E55, w);
    check("R10 first word forwarded", {15'h0, sout_fs}, 16'h0001);
    check("R10 no strobe early", {15'h0, dac_stb}, 16'h0000);
    frame_io(1'b1, 16'h1357, w);
    check("R11 address not decremented", w, 16'h8E55);
    check("R10 dac latched", dac_word, 16'h1357);
    check("R10 strobe and no forward", {14'h0, dac_stb, sout_fs}, 16'h0002);
    @(negedge clk);
    check("R10 strobe one cycle", {15'h0, dac_stb}, 16'h0000);
    frame_io(1'b1, 16'hC000, w);
    check("R11 ctrl_a locked", {8'h0, ctrl_a}, 16'h000A);
    check("R11 control word forwarded", {15'h0, sout_fs}, 16'h0001);
    frame_io(1'b1, 16'h3333, w);
    check("R11 control word unchanged", w, 16'hC000);
    check("R10 counter restarted", dac_word, 16'h3333);
  endtask

  task automatic test_count_eight();
    logic [15:0] w;
    int early;
    do_reset();
    frame_io(1'b1, 16'hC008, w);
    check("R9 ctrl_a count zero", {8'h0, ctrl_a}, 16'h0008);
    early = 0;
    for (int i = 0; i < 7; i++) begin
      frame_io(1'b1, 16'h0100 + 16'(i), w);
      if (dac_stb || !sout_fs) early++;
    end
    check("R9 seven frames passed", 16'(early), 16'h0000);
    frame_io(1'b1, 16'h4321, w);
    check("R9 eighth frame latched", dac_word, 16'h4321);
    check("R9 eighth strobe", {15'h0, dac_stb}, 16'h0001);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_adc_pass();
    test_write_read();
    test_bad_reg();
    test_data_mode();
    test_count_eight();
    finish_run();
  end

endmodule